// File: doc/BRIEF.md
# Preemptive Path/Guardian Activation Manager

This block arbitrates two classes of monitoring tasks that share one execution slot each. "Path" tasks do routine work, and at most one of them runs at a time. "Guardian" tasks handle exceptional events, and at most one of them is active at a time. Each task has its own trigger input and its own done input. Triggers are sampled on every clock edge. A trigger that cannot be granted on that edge is dropped and is not remembered.

A guardian outranks every path. When a guardian is granted while a path is running, the path is not aborted: it is held frozen with its index kept. When the guardian finishes, the frozen path either resumes or, if the guardian asserts its reset request on its finishing cycle, is sent back to idle. Among triggers of the same class that are true in the same cycle, the lowest index wins. All outputs are registered one-hot vectors, one bit per task, and each task uses its bit as a run enable or a freeze indication.

Top module: `preempt_task_mgr`

## Requirements
- R1: After reset, `path_run`, `path_frozen` and `guard_run` are all zero.
- R2: A path trigger is granted only when no path is running or frozen and no guardian is active. The chosen path is the lowest set index, and its `path_run` bit rises on the clock edge that samples the trigger.
- R3: A path trigger sampled while a path is running or frozen, or while a guardian is active, is ignored and is not remembered once it goes away.
- R4: Raising the running path's own `path_done` bit returns the path machine to idle on that edge. A `path_done` bit of any other index has no effect.
- R5: A guardian trigger is granted whenever no guardian is active, with the lowest set index winning. On that edge every path trigger is ignored.
- R6: A guardian trigger sampled while a guardian is active is ignored, and the active guardian keeps its bit.
- R7: Granting a guardian while a path is running clears that path's `path_run` bit and sets its `path_frozen` bit at the same index, on the same edge.
- R8: When the active guardian raises its own `guard_done` bit with `guard_reset_req` low, the guardian becomes idle and the frozen path returns to running at the same index.
- R9: When the active guardian raises its own `guard_done` bit with `guard_reset_req` high, the guardian becomes idle and the frozen path goes to idle. Both `path_run` and `path_frozen` become zero.
- R10: At most one bit of `path_run | path_frozen` is set, at most one bit of `guard_run` is set, and `path_run` is zero whenever a guardian is active.
- R11: `path_done` for a frozen path is ignored. The path stays frozen.
- R12: If the running path's `path_done` and a guardian trigger arrive in the same cycle, the path goes to idle and the guardian is granted. No path is frozen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously |
| path_trig | input | NUM_PATHS | Per-path activation condition, sampled each cycle |
| path_done | input | NUM_PATHS | Per-path completion indication |
| guard_trig | input | NUM_GUARDS | Per-guardian activation condition, sampled each cycle |
| guard_done | input | NUM_GUARDS | Per-guardian completion indication |
| guard_reset_req | input | 1 | Qualifies a guardian's completion: abort the frozen path instead of resuming it |
| path_run | output | NUM_PATHS | One-hot run enable for the granted path |
| path_frozen | output | NUM_PATHS | One-hot freeze indication for a suspended path |
| guard_run | output | NUM_GUARDS | One-hot run enable for the active guardian |

## Verification
The properties assume that `guard_reset_req` matters only in the cycle in which the active guardian signals completion, and that the done bits of idle tasks may take any value. The design ignores both, so the properties never rely on the inputs being clean. The bench drives every input for exactly one cycle, changing it on the falling clock edge, and returns every input to zero before the next scenario. It also deliberately raises done bits for the wrong index and for a frozen path, so that the ignore rules are exercised.

// File: rtl/ptm_pkg.sv
package ptm_pkg;
  typedef enum logic [1:0] {
    PS_IDLE   = 2'd0,
    PS_RUN    = 2'd1,
    PS_FROZEN = 2'd2
  } path_state_t;

  typedef enum logic {
    GS_IDLE   = 1'b0,
    GS_ACTIVE = 1'b1
  } guard_state_t;
endpackage

// File: rtl/ptm_prio_pick.sv
module ptm_prio_pick #(
  parameter int W  = 4,
  parameter int IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  req,
  output logic          any,
  output logic [IW-1:0] idx
);
  always_comb begin
    any = 1'b0;
    idx = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req[i]) begin
        any = 1'b1;
        idx = IW'(i);
      end
    end
  end
endmodule

// File: rtl/ptm_guard_fsm.sv
module ptm_guard_fsm
  import ptm_pkg::*;
#(
  parameter int NUM_GUARDS = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_GUARDS-1:0] trig,
  input  logic [NUM_GUARDS-1:0] done,
  input  logic                  reset_req,
  output logic                  busy,
  output logic                  start,
  output logic                  finish,
  output logic                  abort,
  output logic [NUM_GUARDS-1:0] run
);
  localparam int GIW = (NUM_GUARDS > 1) ? $clog2(NUM_GUARDS) : 1;

  guard_state_t st_q, st_d;
  logic [GIW-1:0] idx_q;
  logic [GIW-1:0] pick_idx;
  logic           pick_any;
  logic           idx_en;

  ptm_prio_pick #(.W(NUM_GUARDS), .IW(GIW)) u_pick (
    .req (trig),
    .any (pick_any),
    .idx (pick_idx)
  );

  assign busy   = (st_q == GS_ACTIVE);
  assign start  = !busy && pick_any;
  assign finish = busy && done[idx_q];
  assign abort  = finish && reset_req;
  assign idx_en = start;

  always_comb begin
    st_d = st_q;
    if (start)       st_d = GS_ACTIVE;
    else if (finish) st_d = GS_IDLE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= GS_IDLE;
      idx_q <= '0;
    end else begin
      st_q <= st_d;
      if (idx_en) idx_q <= pick_idx;
    end
  end

  for (genvar g = 0; g < NUM_GUARDS; g++) begin : g_run
    assign run[g] = busy && (idx_q == GIW'(g));
  end
endmodule

// File: rtl/ptm_path_fsm.sv
module ptm_path_fsm
  import ptm_pkg::*;
#(
  parameter int NUM_PATHS = 4
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_PATHS-1:0] trig,
  input  logic [NUM_PATHS-1:0] done,
  input  logic                 guard_busy,
  input  logic                 guard_start,
  input  logic                 guard_finish,
  input  logic                 guard_abort,
  output logic [NUM_PATHS-1:0] run,
  output logic [NUM_PATHS-1:0] frozen
);
  localparam int PIW = (NUM_PATHS > 1) ? $clog2(NUM_PATHS) : 1;

  path_state_t    st_q, st_d;
  logic [PIW-1:0] idx_q;
  logic [PIW-1:0] pick_idx;
  logic           pick_any;
  logic           idx_en;

  ptm_prio_pick #(.W(NUM_PATHS), .IW(PIW)) u_pick (
    .req (trig),
    .any (pick_any),
    .idx (pick_idx)
  );

  always_comb begin
    st_d   = st_q;
    idx_en = 1'b0;
    unique case (st_q)
      PS_IDLE: begin
        if (!guard_busy && !guard_start && pick_any) begin
          st_d   = PS_RUN;
          idx_en = 1'b1;
        end
      end
      PS_RUN: begin
        if (done[idx_q])      st_d = PS_IDLE;
        else if (guard_start) st_d = PS_FROZEN;
      end
      PS_FROZEN: begin
        if (guard_finish) st_d = guard_abort ? PS_IDLE : PS_RUN;
      end
      default: st_d = PS_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q  <= PS_IDLE;
      idx_q <= '0;
    end else begin
      st_q <= st_d;
      if (idx_en) idx_q <= pick_idx;
    end
  end

  for (genvar p = 0; p < NUM_PATHS; p++) begin : g_out
    assign run[p]    = (st_q == PS_RUN)    && (idx_q == PIW'(p));
    assign frozen[p] = (st_q == PS_FROZEN) && (idx_q == PIW'(p));
  end
endmodule

// File: rtl/preempt_task_mgr.sv
module preempt_task_mgr #(
  parameter int NUM_PATHS  = 4,
  parameter int NUM_GUARDS = 3
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic [NUM_PATHS-1:0]  path_trig,
  input  logic [NUM_PATHS-1:0]  path_done,
  input  logic [NUM_GUARDS-1:0] guard_trig,
  input  logic [NUM_GUARDS-1:0] guard_done,
  input  logic                  guard_reset_req,
  output logic [NUM_PATHS-1:0]  path_run,
  output logic [NUM_PATHS-1:0]  path_frozen,
  output logic [NUM_GUARDS-1:0] guard_run
);
  logic g_busy, g_start, g_finish, g_abort;

  ptm_guard_fsm #(.NUM_GUARDS(NUM_GUARDS)) u_guard (
    .clk       (clk),
    .rst_n     (rst_n),
    .trig      (guard_trig),
    .done      (guard_done),
    .reset_req (guard_reset_req),
    .busy      (g_busy),
    .start     (g_start),
    .finish    (g_finish),
    .abort     (g_abort),
    .run       (guard_run)
  );

  ptm_path_fsm #(.NUM_PATHS(NUM_PATHS)) u_path (
    .clk          (clk),
    .rst_n        (rst_n),
    .trig         (path_trig),
    .done         (path_done),
    .guard_busy   (g_busy),
    .guard_start  (g_start),
    .guard_finish (g_finish),
    .guard_abort  (g_abort),
    .run          (path_run),
    .frozen       (path_frozen)
  );
endmodule

// File: rtl/preempt_task_mgr_chk.sv
module preempt_task_mgr_chk #(
  parameter int NUM_PATHS  = 4,
  parameter int NUM_GUARDS = 3
) (
  input logic                  clk,
  input logic                  rst_n,
  input logic [NUM_PATHS-1:0]  path_trig,
  input logic [NUM_PATHS-1:0]  path_done,
  input logic [NUM_GUARDS-1:0] guard_trig,
  input logic [NUM_GUARDS-1:0] guard_done,
  input logic                  guard_reset_req,
  input logic [NUM_PATHS-1:0]  path_run,
  input logic [NUM_PATHS-1:0]  path_frozen,
  input logic [NUM_GUARDS-1:0] guard_run
);
  // R10
  path_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(path_run | path_frozen));

  // R10
  guard_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(guard_run));

  // R10
  no_run_under_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (guard_run != '0) |-> (path_run == '0));

  // R3
  path_blocked_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (guard_run != '0 && path_run == '0 && path_frozen == '0) |=> (path_run == '0));

  // R6
  guard_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (guard_run != '0 && (guard_run & guard_done) == '0) |=> (guard_run == $past(guard_run)));

  // R7
  freeze_on_guard_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (path_run != '0 && (path_run & path_done) == '0 && guard_run == '0 && guard_trig != '0)
      |=> (path_frozen == $past(path_run) && path_run == '0));

  // R8
  resume_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((guard_run & guard_done) != '0 && path_frozen != '0 && !guard_reset_req)
      |=> (path_run == $past(path_frozen) && guard_run == '0));

  // R9
  abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((guard_run & guard_done) != '0 && path_frozen != '0 && guard_reset_req)
      |=> (path_run == '0 && path_frozen == '0));

  // R11
  frozen_stays_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (path_frozen != '0 && (guard_run & guard_done) == '0) |=> $stable(path_frozen));
endmodule

bind preempt_task_mgr preempt_task_mgr_chk #(
  .NUM_PATHS  (NUM_PATHS),
  .NUM_GUARDS (NUM_GUARDS)
) u_chk (.*);

// File: tb/preempt_task_mgr_bench.sv
module preempt_task_mgr_bench;
  localparam int NP = 4;
  localparam int NG = 3;

  logic          clk;
  logic          rst_n;
  logic [NP-1:0] path_trig, path_done, path_run, path_frozen;
  logic [NG-1:0] guard_trig, guard_done, guard_run;
  logic          guard_reset_req;
  int            total, bad;
  bit            finished;

  preempt_task_mgr #(.NUM_PATHS(NP), .NUM_GUARDS(NG)) u_preempt_task_mgr (
    .clk             (clk),
    .rst_n           (rst_n),
    .path_trig       (path_trig),
    .path_done       (path_done),
    .guard_trig      (guard_trig),
    .guard_done      (guard_done),
    .guard_reset_req (guard_reset_req),
    .path_run        (path_run),
    .path_frozen     (path_frozen),
    .guard_run       (guard_run)
  );

  initial clk = 1'b0;
  always #5 clk = ~clk;

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%b exp=%b", tag, act, exp);
    end
  endtask

  task automatic chk_all(input string tag, input logic [NP-1:0] er,
                         input logic [NP-1:0] ef, input logic [NG-1:0] eg);
    chk({tag, " path_run"},    8'(path_run),    8'(er));
    chk({tag, " path_frozen"}, 8'(path_frozen), 8'(ef));
    chk({tag, " guard_run"},   8'(guard_run),   8'(eg));
  endtask

  // Drive inputs for one cycle; outputs are sampled at the following falling edge.
  task automatic step(input logic [NP-1:0] pt, input logic [NP-1:0] pd,
                      input logic [NG-1:0] gt, input logic [NG-1:0] gd, input logic rr);
    path_trig = pt; path_done = pd; guard_trig = gt; guard_done = gd; guard_reset_req = rr;
    @(negedge clk);
    path_trig = '0; path_done = '0; guard_trig = '0; guard_done = '0; guard_reset_req = 1'b0;
  endtask

  task automatic t_reset;
    chk_all("R1 reset", 4'b0000, 4'b0000, 3'b000);
  endtask

  task automatic t_path_basic;
    step(4'b1010, 0, 0, 0, 0);
    chk_all("R2 lowest path wins", 4'b0010, 4'b0000, 3'b000);
    step(4'b0001, 0, 0, 0, 0);
    chk_all("R3 trigger while running", 4'b0010, 4'b0000, 3'b000);
    step(0, 4'b0001, 0, 0, 0);
    chk_all("R4 foreign done", 4'b0010, 4'b0000, 3'b000);
    step(0, 4'b0010, 0, 0, 0);
    chk_all("R4 own done", 4'b0000, 4'b0000, 3'b000);
    step(0, 0, 0, 0, 0);
    chk_all("R3 not remembered", 4'b0000, 4'b0000, 3'b000);
  endtask

  task automatic t_freeze_resume;
    step(4'b0100, 0, 0, 0, 0);
    chk_all("R2 path start", 4'b0100, 4'b0000, 3'b000);
    step(0, 0, 3'b110, 0, 0);
    chk_all("R7 R5 guard freezes path", 4'b0000, 4'b0100, 3'b010);
    step(0, 0, 3'b001, 0, 0);
    chk_all("R6 second guard ignored", 4'b0000, 4'b0100, 3'b010);
    step(4'b0001, 0, 0, 0, 0);
    chk_all("R3 path under guard", 4'b0000, 4'b0100, 3'b010);
    step(0, 4'b0100, 0, 0, 0);
    chk_all("R11 frozen done ignored", 4'b0000, 4'b0100, 3'b010);
    step(0, 0, 0, 3'b001, 0);
    chk_all("R6 foreign guard done", 4'b0000, 4'b0100, 3'b010);
    step(0, 0, 0, 3'b010, 0);
    chk_all("R8 resume", 4'b0100, 4'b0000, 3'b000);
    chk("R10 one path", 8'($countones(path_run | path_frozen)), 8'd1);
    step(0, 4'b0100, 0, 0, 0);
    chk_all("R4 resumed path done", 4'b0000, 4'b0000, 3'b000);
  endtask

  task automatic t_abort;
    step(4'b1000, 0, 0, 0, 0);
    chk_all("R2 high path", 4'b1000, 4'b0000, 3'b000);
    step(0, 0, 3'b100, 0, 0);
    chk_all("R7 freeze", 4'b0000, 4'b1000, 3'b100);
    step(0, 0, 0, 3'b100, 1'b1);
    chk_all("R9 abort", 4'b0000, 4'b0000, 3'b000);
  endtask

  task automatic t_guard_beats_path;
    step(4'b0001, 0, 3'b001, 0, 0);
    chk_all("R5 guard over path trig", 4'b0000, 4'b0000, 3'b001);
    step(0, 0, 0, 3'b001, 1'b0);
    chk_all("R3 dropped path trig", 4'b0000, 4'b0000, 3'b000);
  endtask

  task automatic t_done_and_guard;
    step(4'b0001, 0, 0, 0, 0);
    chk_all("R2 path0", 4'b0001, 4'b0000, 3'b000);
    step(0, 4'b0001, 3'b010, 0, 0);
    chk_all("R12 done with guard", 4'b0000, 4'b0000, 3'b010);
    step(0, 0, 0, 3'b010, 0);
    chk_all("R8 no path to resume", 4'b0000, 4'b0000, 3'b000);
  endtask

  initial begin
    total = 0; bad = 0; finished = 0;
    rst_n = 1'b0;
    path_trig = '0; path_done = '0; guard_trig = '0; guard_done = '0; guard_reset_req = 1'b0;
    repeat (3) @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_path_basic;
    t_freeze_resume;
    t_abort;
    t_guard_beats_path;
    t_done_and_guard;
    finished = 1;
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!finished) begin
      total++;
      bad++;
      $display("FAIL watchdog act=running exp=done");
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule